// File: doc/BRIEF.md
# Data Access Translation and Fault Classifier

This block sits between a load/store unit and the rest of the memory pipeline. Each cycle it may accept one data access request: a 64-bit virtual address, the access size, a write flag, a physical-bypass flag, an alternate-mode flag and a page-table-fetch flag. It also receives the current privilege mode, the alternate mode and whether the core is running privileged firmware code. The translation buffer itself is outside the block. Its lookup result (hit, page frame number, per-mode read and write enables, fault-on-read and fault-on-write bits) arrives on input ports in the same cycle as the request.

The block runs a fixed sequence of checks. It tests alignment, selects the effective privilege mode, validates the virtual address and recognises the kernel direct-mapped window. It then judges miss, permission and fault-on conditions, checks the physical address against the implemented width, and decodes uncacheable space. One cycle after the request it presents a registered result. That result is either a physical address with an uncacheable flag, or a fault code with a status vector that holds one bit per detected condition.

Top module: `xlat_dchk`

## Requirements
- R1: The result appears on the rsp_* ports exactly one clock after a request with req_valid high. A cycle with req_valid low yields rsp_valid=0 and all other outputs zero. After reset every output is zero.
- R2: Status bit positions are: bit0 write, bit1 access violation, bit2 bad address, bit3 miss, bit4 fault-on-read, bit5 fault-on-write. The access is misaligned when any of the low bits of the address, masked with (2^req_size_lg - 1), is set. A misaligned access gets fault code 1 with only the write bit (set for writes) in the status. This check overrides every other check, including the physical flag.
- R3: With req_phys set, the virtual address is taken unchanged as the physical address. No address validity, direct-window or buffer checks apply.
- R4: A virtual address is invalid when bits 63:42 are neither all zeros nor all ones. It gets fault code 2 with status bad-address and access-violation, plus the write bit for writes.
- R5: An address whose bits 47:41 equal 0x7e is in the direct window. The window is allowed only when cur_mode is 0 (kernel); the firmware-mode override does not apply to this test. Otherwise the access gets fault code 3 with status access-violation, plus write for writes.
- R6: A permitted direct-window access takes bits 39:0 of the virtual address. If bit 40 is set, bits 43:40 of the physical address become ones; otherwise they are zero.
- R7: A buffer miss gets fault code 4, or fault code 5 when req_pte is set. The status has the miss bit, plus write for writes.
- R8: On a hit the physical address is the page frame number shifted left by 13, with virtual bits 12:0 below it. The effective mode is cur_mode outside firmware code. In firmware code it is alt_mode when req_alt is set, and mode 0 otherwise.
- R9: A write needs tlb_wr_en[mode] and a read needs tlb_rd_en[mode] for the effective mode. A failed write gets code 2 with status write and access-violation, plus fault-on-write if that bit is set. A failed read gets code 3 with status access-violation, plus fault-on-read if that bit is set.
- R10: A permitted write with tlb_fow set gets code 2 with status write and fault-on-write. A permitted read with tlb_for set gets code 2 with status fault-on-read.
- R11: A physical address with any bit at or above bit 44 set gets fault code 6 with zero status.
- R12: If physical bit 43 is set, the access is uncacheable: rsp_uncached=1 and bits 42:35 are cleared. If bits 34:32 are also all ones, it gets fault code 7 with zero status instead.
- R13: Whenever the fault code is nonzero, rsp_pa and rsp_uncached are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | 64 | Virtual address |
| req_size_lg | input | 2 | log2 of access size in bytes |
| req_write | input | 1 | Access is a write |
| req_phys | input | 1 | Physical bypass |
| req_alt | input | 1 | Use alternate mode in firmware code |
| req_pte | input | 1 | Access is a page-table-entry fetch |
| pal_mode | input | 1 | Core is running privileged firmware code |
| cur_mode | input | 2 | Current privilege mode, 0 = kernel |
| alt_mode | input | 2 | Alternate privilege mode |
| tlb_hit | input | 1 | Buffer lookup hit |
| tlb_ppn | input | 32 | Page frame number of the hit |
| tlb_rd_en | input | 4 | Read enable, one bit per mode |
| tlb_wr_en | input | 4 | Write enable, one bit per mode |
| tlb_for | input | 1 | Fault-on-read bit of the entry |
| tlb_fow | input | 1 | Fault-on-write bit of the entry |
| rsp_valid | output | 1 | Result valid |
| rsp_fault | output | 3 | Fault code, 0 = none |
| rsp_status | output | 6 | Condition status bits |
| rsp_pa | output | 44 | Physical address |
| rsp_uncached | output | 1 | Access is uncacheable |

## Verification
The only state in the block is the one-cycle result register. A wrong value there shows on the ports in the cycle after the request and does not persist past the next request. A wrong intermediate decision instead shows up as the wrong fault code, status bit or address bits in that same response. The bench therefore compares every response field on every clock against a behavioural model. It uses directed stimuli at each decision boundary: the alignment override, the firmware-mode override, the window kernel test, the bit-40 extension and the register-space carve-out. Randomised accesses then cover the mixed cases.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   typedef enum logic [2:0] {
      FLT_NONE     = 3'd0,
      FLT_ALIGN    = 3'd1,
      FLT_PAGE     = 3'd2,
      FLT_ACV      = 3'd3,
      FLT_MISS     = 3'd4,
      FLT_MISS_PTE = 3'd5,
      FLT_MCHK     = 3'd6,
      FLT_UNIMP    = 3'd7
   } flt_e;

   localparam int ST_W     = 6;
   localparam int ST_WR    = 0;
   localparam int ST_ACV   = 1;
   localparam int ST_BADVA = 2;
   localparam int ST_MISS  = 3;
   localparam int ST_FONR  = 4;
   localparam int ST_FONW  = 5;

   typedef enum logic [1:0] {
      SRC_NONE  = 2'd0,
      SRC_RAW   = 2'd1,
      SRC_SUPER = 2'd2,
      SRC_TLB   = 2'd3
   } pa_src_e;

endpackage

// File: rtl/xlat_mode_sel.sv
module xlat_mode_sel #(
   parameter int MODE_W = 2
) (
   input  logic              pal_mode,
   input  logic              alt_sel,
   input  logic [MODE_W-1:0] cur_mode,
   input  logic [MODE_W-1:0] alt_mode,
   output logic [MODE_W-1:0] eff_mode
);
   localparam logic [MODE_W-1:0] KERNEL = '0;

   always_comb begin
      if (pal_mode)
         eff_mode = alt_sel ? alt_mode : KERNEL;
      else
         eff_mode = cur_mode;
   end
endmodule

// File: rtl/xlat_addr_form.sv
module xlat_addr_form #(
   parameter int VA_W        = 64,
   parameter int PA_W        = 44,
   parameter int PPN_W       = 32,
   parameter int PAGE_SHIFT  = 13,
   parameter int SP_EXT_BIT  = 40,
   parameter bit SP_SIGN_EXT = 1'b1
) (
   input  logic [VA_W-1:0]  va,
   input  logic [PPN_W-1:0] ppn,
   output logic [VA_W-1:0]  raw_pa,
   output logic [VA_W-1:0]  sp_pa,
   output logic [VA_W-1:0]  tlb_pa
);
   localparam int EXT_W = PA_W - SP_EXT_BIT;

   assign raw_pa = va;

   always_comb begin
      tlb_pa = VA_W'(ppn) << PAGE_SHIFT;
      tlb_pa[PAGE_SHIFT-1:0] = va[PAGE_SHIFT-1:0];
   end

   generate
      if (SP_SIGN_EXT) begin : g_sp_ext
         always_comb begin
            sp_pa = '0;
            sp_pa[SP_EXT_BIT-1:0] = va[SP_EXT_BIT-1:0];
            sp_pa[PA_W-1:SP_EXT_BIT] = va[SP_EXT_BIT] ? {EXT_W{1'b1}} : {EXT_W{1'b0}};
         end
      end else begin : g_sp_plain
         always_comb begin
            sp_pa = '0;
            sp_pa[PA_W-1:0] = va[PA_W-1:0];
         end
      end
   endgenerate
endmodule

// File: rtl/xlat_fault_order.sv
module xlat_fault_order
   import xlat_pkg::*;
#(
   parameter int VA_W        = 64,
   parameter int MODE_W      = 2,
   parameter int SIZE_LG_W   = 2,
   parameter int VA_SIGN_BIT = 42,
   parameter int SP_HI       = 47,
   parameter int SP_LO       = 41,
   parameter int SP_TAG      = 'h7e
) (
   input  logic [VA_W-1:0]       va,
   input  logic [SIZE_LG_W-1:0]  size_lg,
   input  logic                  is_wr,
   input  logic                  phys,
   input  logic                  pte,
   input  logic [MODE_W-1:0]     cur_mode,
   input  logic [MODE_W-1:0]     eff_mode,
   input  logic                  hit,
   input  logic [(1<<MODE_W)-1:0] rd_en,
   input  logic [(1<<MODE_W)-1:0] wr_en,
   input  logic                  fonr,
   input  logic                  fonw,
   output flt_e                  fault,
   output logic [ST_W-1:0]       status,
   output pa_src_e               src
);
   localparam int ALN_W  = (1 << SIZE_LG_W) - 1;
   localparam int SP_W   = SP_HI - SP_LO + 1;
   localparam int TOP_W  = VA_W - VA_SIGN_BIT;

   logic [ALN_W:0]    size_oh;
   logic [ALN_W-1:0]  aln_mask;
   logic              misal;
   logic [TOP_W-1:0]  va_top;
   logic              va_ok;
   logic              in_sp;
   logic              kern;
   logic              rd_ok;
   logic              wr_ok;

   assign size_oh  = (ALN_W+1)'(1) << size_lg;
   assign aln_mask = ALN_W'(size_oh - 1'b1);
   assign misal    = |(va[ALN_W-1:0] & aln_mask);
   assign va_top   = va[VA_W-1:VA_SIGN_BIT];
   assign va_ok    = (&va_top) | ~(|va_top);
   assign in_sp    = (va[SP_HI:SP_LO] == SP_W'(SP_TAG));
   assign kern     = (cur_mode == '0);
   assign rd_ok    = rd_en[eff_mode];
   assign wr_ok    = wr_en[eff_mode];

   always_comb begin
      fault  = FLT_NONE;
      status = '0;
      src    = SRC_NONE;
      if (misal) begin
         fault         = FLT_ALIGN;
         status[ST_WR] = is_wr;
      end else if (phys) begin
         src = SRC_RAW;
      end else if (!va_ok) begin
         fault            = FLT_PAGE;
         status[ST_WR]    = is_wr;
         status[ST_ACV]   = 1'b1;
         status[ST_BADVA] = 1'b1;
      end else if (in_sp) begin
         if (!kern) begin
            fault          = FLT_ACV;
            status[ST_WR]  = is_wr;
            status[ST_ACV] = 1'b1;
         end else begin
            src = SRC_SUPER;
         end
      end else if (!hit) begin
         fault           = pte ? FLT_MISS_PTE : FLT_MISS;
         status[ST_WR]   = is_wr;
         status[ST_MISS] = 1'b1;
      end else if (is_wr) begin
         status[ST_WR] = 1'b1;
         if (!wr_ok) begin
            fault           = FLT_PAGE;
            status[ST_ACV]  = 1'b1;
            status[ST_FONW] = fonw;
         end else if (fonw) begin
            fault           = FLT_PAGE;
            status[ST_FONW] = 1'b1;
         end else begin
            status[ST_WR] = 1'b0;
            src           = SRC_TLB;
         end
      end else begin
         if (!rd_ok) begin
            fault           = FLT_ACV;
            status[ST_ACV]  = 1'b1;
            status[ST_FONR] = fonr;
         end else if (fonr) begin
            fault           = FLT_PAGE;
            status[ST_FONR] = 1'b1;
         end else begin
            src = SRC_TLB;
         end
      end
   end
endmodule

// File: rtl/xlat_pa_check.sv
module xlat_pa_check
   import xlat_pkg::*;
#(
   parameter int VA_W   = 64,
   parameter int PA_W   = 44,
   parameter int UC_BIT = 43,
   parameter int CLR_HI = 42,
   parameter int CLR_LO = 35,
   parameter int REG_HI = 34,
   parameter int REG_LO = 32
) (
   input  flt_e             fault_in,
   input  logic [ST_W-1:0]  status_in,
   input  pa_src_e          src,
   input  logic [VA_W-1:0]  raw_pa,
   input  logic [VA_W-1:0]  sp_pa,
   input  logic [VA_W-1:0]  tlb_pa,
   output flt_e             fault,
   output logic [ST_W-1:0]  status,
   output logic [PA_W-1:0]  pa,
   output logic             uc
);
   localparam int CLR_W = CLR_HI - CLR_LO + 1;

   logic [VA_W-1:0] sel;
   logic            over;
   logic            reg_win;

   always_comb begin
      unique case (src)
         SRC_RAW:   sel = raw_pa;
         SRC_SUPER: sel = sp_pa;
         SRC_TLB:   sel = tlb_pa;
         default:   sel = '0;
      endcase
   end

   assign over    = |sel[VA_W-1:PA_W];
   assign reg_win = &sel[REG_HI:REG_LO];

   always_comb begin
      fault  = fault_in;
      status = status_in;
      pa     = '0;
      uc     = 1'b0;
      if (fault_in == FLT_NONE) begin
         if (over) begin
            fault  = FLT_MCHK;
            status = '0;
         end else if (sel[UC_BIT]) begin
            if (reg_win) begin
               fault  = FLT_UNIMP;
               status = '0;
            end else begin
               pa                = sel[PA_W-1:0];
               pa[CLR_HI:CLR_LO] = {CLR_W{1'b0}};
               uc                = 1'b1;
            end
         end else begin
            pa = sel[PA_W-1:0];
         end
      end
   end
endmodule

// File: rtl/xlat_dchk.sv
module xlat_dchk
   import xlat_pkg::*;
#(
   parameter int VA_W        = 64,
   parameter int PA_W        = 44,
   parameter int PPN_W       = 32,
   parameter int PAGE_SHIFT  = 13,
   parameter int MODE_W      = 2,
   parameter int SIZE_LG_W   = 2,
   parameter int VA_SIGN_BIT = 42,
   parameter int SP_HI       = 47,
   parameter int SP_LO       = 41,
   parameter int SP_TAG      = 'h7e,
   parameter int SP_EXT_BIT  = 40,
   parameter bit SP_SIGN_EXT = 1'b1,
   parameter int CLR_HI      = 42,
   parameter int CLR_LO      = 35,
   parameter int REG_HI      = 34,
   parameter int REG_LO      = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic [VA_W-1:0]         req_va,
   input  logic [SIZE_LG_W-1:0]    req_size_lg,
   input  logic                    req_write,
   input  logic                    req_phys,
   input  logic                    req_alt,
   input  logic                    req_pte,
   input  logic                    pal_mode,
   input  logic [MODE_W-1:0]       cur_mode,
   input  logic [MODE_W-1:0]       alt_mode,
   input  logic                    tlb_hit,
   input  logic [PPN_W-1:0]        tlb_ppn,
   input  logic [(1<<MODE_W)-1:0]  tlb_rd_en,
   input  logic [(1<<MODE_W)-1:0]  tlb_wr_en,
   input  logic                    tlb_for,
   input  logic                    tlb_fow,
   output logic                    rsp_valid,
   output logic [2:0]              rsp_fault,
   output logic [ST_W-1:0]         rsp_status,
   output logic [PA_W-1:0]         rsp_pa,
   output logic                    rsp_uncached
);
   localparam int UC_BIT = PA_W - 1;

   generate
      if (PA_W > VA_W) begin : g_bad_pa
         $error("physical width exceeds virtual width");
      end
      if (PPN_W + PAGE_SHIFT > VA_W) begin : g_bad_ppn
         $error("frame number and page offset exceed virtual width");
      end
      if (CLR_HI >= UC_BIT || CLR_LO > CLR_HI) begin : g_bad_clr
         $error("cleared field must sit below the uncacheable bit");
      end
      if (REG_HI >= CLR_LO || REG_LO > REG_HI) begin : g_bad_reg
         $error("register window field must sit below the cleared field");
      end
      if (SP_HI >= VA_W || SP_LO > SP_HI || SP_EXT_BIT >= PA_W) begin : g_bad_sp
         $error("direct window fields out of range");
      end
      if (VA_SIGN_BIT >= VA_W || (1 << SIZE_LG_W) - 1 > PAGE_SHIFT) begin : g_bad_va
         $error("virtual address fields out of range");
      end
   endgenerate

   logic [MODE_W-1:0] eff_mode;
   logic [VA_W-1:0]   raw_pa, sp_pa, tlb_pa;
   flt_e              fault_a, fault_b;
   logic [ST_W-1:0]   status_a, status_b;
   pa_src_e           src;
   logic [PA_W-1:0]   pa_b;
   logic              uc_b;

   xlat_mode_sel #(.MODE_W(MODE_W)) u_mode (
      .pal_mode (pal_mode),
      .alt_sel  (req_alt),
      .cur_mode (cur_mode),
      .alt_mode (alt_mode),
      .eff_mode (eff_mode)
   );

   xlat_addr_form #(
      .VA_W(VA_W), .PA_W(PA_W), .PPN_W(PPN_W), .PAGE_SHIFT(PAGE_SHIFT),
      .SP_EXT_BIT(SP_EXT_BIT), .SP_SIGN_EXT(SP_SIGN_EXT)
   ) u_form (
      .va     (req_va),
      .ppn    (tlb_ppn),
      .raw_pa (raw_pa),
      .sp_pa  (sp_pa),
      .tlb_pa (tlb_pa)
   );

   xlat_fault_order #(
      .VA_W(VA_W), .MODE_W(MODE_W), .SIZE_LG_W(SIZE_LG_W),
      .VA_SIGN_BIT(VA_SIGN_BIT), .SP_HI(SP_HI), .SP_LO(SP_LO), .SP_TAG(SP_TAG)
   ) u_order (
      .va       (req_va),
      .size_lg  (req_size_lg),
      .is_wr    (req_write),
      .phys     (req_phys),
      .pte      (req_pte),
      .cur_mode (cur_mode),
      .eff_mode (eff_mode),
      .hit      (tlb_hit),
      .rd_en    (tlb_rd_en),
      .wr_en    (tlb_wr_en),
      .fonr     (tlb_for),
      .fonw     (tlb_fow),
      .fault    (fault_a),
      .status   (status_a),
      .src      (src)
   );

   xlat_pa_check #(
      .VA_W(VA_W), .PA_W(PA_W), .UC_BIT(UC_BIT), .CLR_HI(CLR_HI),
      .CLR_LO(CLR_LO), .REG_HI(REG_HI), .REG_LO(REG_LO)
   ) u_pachk (
      .fault_in  (fault_a),
      .status_in (status_a),
      .src       (src),
      .raw_pa    (raw_pa),
      .sp_pa     (sp_pa),
      .tlb_pa    (tlb_pa),
      .fault     (fault_b),
      .status    (status_b),
      .pa        (pa_b),
      .uc        (uc_b)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_fault    <= '0;
         rsp_status   <= '0;
         rsp_pa       <= '0;
         rsp_uncached <= 1'b0;
      end else if (req_valid) begin
         rsp_valid    <= 1'b1;
         rsp_fault    <= fault_b;
         rsp_status   <= status_b;
         rsp_pa       <= pa_b;
         rsp_uncached <= uc_b;
      end else begin
         rsp_valid    <= 1'b0;
         rsp_fault    <= '0;
         rsp_status   <= '0;
         rsp_pa       <= '0;
         rsp_uncached <= 1'b0;
      end
   end
endmodule

// File: rtl/xlat_dchk_sva.sv
module xlat_dchk_sva #(
   parameter int VA_W      = 64,
   parameter int PA_W      = 44,
   parameter int MODE_W    = 2,
   parameter int SIZE_LG_W = 2,
   parameter int CLR_HI    = 42,
   parameter int CLR_LO    = 35
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic [VA_W-1:0]      req_va,
   input logic [SIZE_LG_W-1:0] req_size_lg,
   input logic                 req_write,
   input logic                 req_phys,
   input logic                 tlb_hit,
   input logic [MODE_W-1:0]    cur_mode,
   input logic                 rsp_valid,
   input logic [2:0]           rsp_fault,
   input logic [5:0]           rsp_status,
   input logic [PA_W-1:0]      rsp_pa,
   input logic                 rsp_uncached
);
   logic [7:0] low_mask;
   logic       misal, top_ok, in_win, plain_phys;

   assign low_mask   = 8'((16'd1 << req_size_lg) - 16'd1);
   assign misal      = (req_va[7:0] & low_mask) != 8'd0;
   assign top_ok     = (req_va[VA_W-1:42] == '0) || (req_va[VA_W-1:42] == '1);
   assign in_win     = req_va[47:41] == 7'h7e;
   assign plain_phys = (req_va[VA_W-1:PA_W-1] == '0);

   a_r1_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && rsp_fault == 3'd0 && rsp_pa == '0));
   a_r2_align_first: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && misal) |=> (rsp_fault == 3'd1 && rsp_status == {5'b0, $past(req_write)}));
   a_r3_phys_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !misal && req_phys && plain_phys) |=>
         (rsp_fault == 3'd0 && rsp_pa == $past(req_va[PA_W-1:0])));
   a_r5_window_kernel: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !misal && !req_phys && top_ok && in_win && cur_mode != '0) |=>
         (rsp_fault == 3'd3));
   a_r7_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !misal && !req_phys && top_ok && !in_win && !tlb_hit) |=>
         ((rsp_fault == 3'd4 || rsp_fault == 3'd5) && rsp_status[3]));
   a_r12_uc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_uncached |-> (rsp_pa[PA_W-1] && rsp_pa[CLR_HI:CLR_LO] == '0));
   a_r13_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_fault != 3'd0) |-> (rsp_pa == '0 && !rsp_uncached));
endmodule

bind xlat_dchk xlat_dchk_sva #(
   .VA_W(VA_W), .PA_W(PA_W), .MODE_W(MODE_W), .SIZE_LG_W(SIZE_LG_W),
   .CLR_HI(CLR_HI), .CLR_LO(CLR_LO)
) u_sva (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
   .req_size_lg(req_size_lg), .req_write(req_write), .req_phys(req_phys),
   .tlb_hit(tlb_hit), .cur_mode(cur_mode), .rsp_valid(rsp_valid),
   .rsp_fault(rsp_fault), .rsp_status(rsp_status), .rsp_pa(rsp_pa),
   .rsp_uncached(rsp_uncached)
);

// File: tb/sim_xlat_dchk.sv
module sim_xlat_dchk;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_write, req_phys, req_alt, req_pte, pal_mode;
   logic [63:0] req_va;
   logic [1:0]  req_size_lg, cur_mode, alt_mode;
   logic        tlb_hit, tlb_for, tlb_fow;
   logic [31:0] tlb_ppn;
   logic [3:0]  tlb_rd_en, tlb_wr_en;
   logic        rsp_valid, rsp_uncached;
   logic [2:0]  rsp_fault;
   logic [5:0]  rsp_status;
   logic [43:0] rsp_pa;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #5 clk = ~clk;

   xlat_dchk u0 (.*);

   typedef struct packed {
      logic        v;
      logic [2:0]  f;
      logic [5:0]  s;
      logic [43:0] pa;
      logic        uc;
   } res_t;

   function automatic res_t model();
      res_t        e;
      logic [63:0] p;
      logic [1:0]  m;
      logic [21:0] top;
      e = '0;
      if (!req_valid) return e;
      e.v = 1'b1;
      if ((req_va & ((64'd1 << req_size_lg) - 64'd1)) != 64'd0) begin
         e.f = 3'd1; e.s = {5'b0, req_write}; return e;
      end
      m = pal_mode ? (req_alt ? alt_mode : 2'd0) : cur_mode;
      if (req_phys) p = req_va;
      else begin
         top = req_va[63:42];
         if (!(top == 22'd0 || top == 22'h3fffff)) begin
            e.f = 3'd2; e.s = 6'b000110 | {5'b0, req_write}; return e;
         end
         if (req_va[47:41] == 7'h7e) begin
            if (cur_mode != 2'd0) begin
               e.f = 3'd3; e.s = 6'b000010 | {5'b0, req_write}; return e;
            end
            p = {24'd0, req_va[39:0]};
            if (req_va[40]) p = p | 64'hF00_0000_0000;
         end else if (!tlb_hit) begin
            e.f = req_pte ? 3'd5 : 3'd4; e.s = 6'b001000 | {5'b0, req_write}; return e;
         end else begin
            p = ({32'd0, tlb_ppn} << 13) | {51'd0, req_va[12:0]};
            if (req_write) begin
               if (!tlb_wr_en[m]) begin
                  e.f = 3'd2; e.s = 6'b000011 | (tlb_fow ? 6'b100000 : 6'b0); return e;
               end
               if (tlb_fow) begin e.f = 3'd2; e.s = 6'b100001; return e; end
            end else begin
               if (!tlb_rd_en[m]) begin
                  e.f = 3'd3; e.s = 6'b000010 | (tlb_for ? 6'b010000 : 6'b0); return e;
               end
               if (tlb_for) begin e.f = 3'd2; e.s = 6'b010000; return e; end
            end
         end
      end
      if ((p >> 44) != 64'd0) begin e.f = 3'd6; return e; end
      if (p[43]) begin
         if (p[34:32] == 3'b111) begin e.f = 3'd7; return e; end
         e.uc = 1'b1;
         p[42:35] = 8'd0;
      end
      e.pa = p[43:0];
      return e;
   endfunction

   task automatic clr();
      req_valid = 1'b0; req_va = '0; req_size_lg = '0; req_write = 1'b0;
      req_phys = 1'b0; req_alt = 1'b0; req_pte = 1'b0; pal_mode = 1'b0;
      cur_mode = '0; alt_mode = '0; tlb_hit = 1'b0; tlb_ppn = '0;
      tlb_rd_en = '0; tlb_wr_en = '0; tlb_for = 1'b0; tlb_fow = 1'b0;
   endtask

   task automatic launch(input string tag);
      res_t e, g;
      e = model();
      @(negedge clk);
      g = {rsp_valid, rsp_fault, rsp_status, rsp_pa, rsp_uncached};
      total++;
      if (g !== e) begin
         bad++;
         $display("FAIL %s: got v=%0b f=%0d s=%b pa=%h uc=%0b expected v=%0b f=%0d s=%b pa=%h uc=%0b",
                  tag, g.v, g.f, g.s, g.pa, g.uc, e.v, e.f, e.s, e.pa, e.uc);
      end
   endtask

   task automatic hit_req(input logic [63:0] va, input logic wr, input logic [31:0] ppn);
      clr();
      req_valid = 1'b1; req_va = va; req_write = wr; req_size_lg = 2'd3;
      tlb_hit = 1'b1; tlb_ppn = ppn; tlb_rd_en = 4'hf; tlb_wr_en = 4'hf;
   endtask

   initial begin
      rst_n = 1'b0;
      clr();
      repeat (3) @(negedge clk);
      total++;
      if ({rsp_valid, rsp_fault, rsp_status, rsp_pa, rsp_uncached} !== '0) begin
         bad++;
         $display("FAIL R1 reset: got %h expected 0",
                  {rsp_valid, rsp_fault, rsp_status, rsp_pa, rsp_uncached});
      end
      rst_n = 1'b1;
      @(negedge clk);

      clr(); launch("R1 idle");
      hit_req(64'h1008, 1'b0, 32'h55); launch("R1 single");

      hit_req(64'h1001, 1'b1, 32'h55); req_size_lg = 2'd1; req_phys = 1'b1;
      launch("R2 misaligned write over phys");
      hit_req(64'hFFFF_0000_0000_0004, 1'b0, 32'h55); req_size_lg = 2'd3;
      launch("R2 misaligned read over bad va");
      hit_req(64'h0000_0000_0000_0006, 1'b0, 32'h55); req_size_lg = 2'd1;
      launch("R2 aligned halfword");

      hit_req(64'h0000_0123_4567_8AB8, 1'b0, 32'h0); req_phys = 1'b1; tlb_hit = 1'b0;
      launch("R3 physical bypass");

      hit_req(64'h0000_0800_0000_0000, 1'b1, 32'h0); launch("R4 invalid va write");
      hit_req(64'h8000_0000_0000_0010, 1'b0, 32'h0); launch("R4 invalid va read");

      hit_req(64'hFFFF_FC00_0000_1000, 1'b0, 32'h0); cur_mode = 2'd2;
      launch("R5 window user read");
      hit_req(64'hFFFF_FC00_0000_1000, 1'b1, 32'h0); cur_mode = 2'd1; pal_mode = 1'b1;
      launch("R5 window firmware not kernel");

      hit_req(64'hFFFF_FC00_0000_1000, 1'b0, 32'h0); launch("R6 window truncate");
      hit_req(64'hFFFF_FD00_0000_2000, 1'b0, 32'h0); launch("R6 window bit40 extend");

      hit_req(64'h2000, 1'b0, 32'h0); tlb_hit = 1'b0; launch("R7 miss normal");
      hit_req(64'h2000, 1'b1, 32'h0); tlb_hit = 1'b0; req_pte = 1'b1; launch("R7 miss pte");

      hit_req(64'h1ABC & ~64'h7, 1'b0, 32'h12345); tlb_rd_en = 4'b0001; launch("R8 hit kernel");
      hit_req(64'h1AB8, 1'b0, 32'h12345); tlb_rd_en = 4'b0001; pal_mode = 1'b1; cur_mode = 2'd3;
      launch("R8 firmware kernel default");
      hit_req(64'h1AB8, 1'b0, 32'h12345); tlb_rd_en = 4'b0100; pal_mode = 1'b1; req_alt = 1'b1;
      alt_mode = 2'd2; launch("R8 firmware alt mode");

      hit_req(64'h1AB8, 1'b0, 32'h12345); tlb_rd_en = 4'b0001; pal_mode = 1'b1; req_alt = 1'b1;
      alt_mode = 2'd2; launch("R9 alt mode read denied");
      hit_req(64'h3000, 1'b1, 32'h77); tlb_wr_en = 4'b1110; tlb_fow = 1'b1;
      launch("R9 write denied with fow");
      hit_req(64'h3000, 1'b0, 32'h77); cur_mode = 2'd3; tlb_rd_en = 4'b0111; tlb_for = 1'b1;
      launch("R9 read denied with for");

      hit_req(64'h3000, 1'b1, 32'h77); tlb_fow = 1'b1; launch("R10 fault on write");
      hit_req(64'h3000, 1'b0, 32'h77); tlb_for = 1'b1; launch("R10 fault on read");

      hit_req(64'h3000, 1'b0, 32'hFFFF_FFFF); launch("R11 hit beyond width");
      hit_req(64'h0010_0000_0000_0000, 1'b0, 32'h0); req_phys = 1'b1; launch("R11 phys beyond width");

      hit_req(64'h0000_0FF0_1234_5678 & ~64'h7, 1'b0, 32'h0); req_phys = 1'b1;
      launch("R12 uncacheable clear");
      hit_req(64'h0000_0807_0000_0040, 1'b0, 32'h0); req_phys = 1'b1;
      launch("R12 register window");
      hit_req(64'h3000, 1'b0, 32'h4000_0007); launch("R12 hit into uncached");

      hit_req(64'h3000, 1'b1, 32'h77); tlb_wr_en = 4'h0; launch("R13 fault clears pa");

      for (int i = 0; i < 2000; i++) begin
         int k;
         clr();
         k = int'($urandom % 6);
         req_valid   = ($urandom % 8) != 0;
         req_size_lg = 2'($urandom);
         req_va      = {$urandom, $urandom};
         if (($urandom % 3) != 0) req_va[2:0] = 3'd0;
         case (k)
            0: req_phys = 1'b1;
            1: req_va[63:41] = {16'hFFFF, 7'h7e};
            2: req_va[63:42] = '0;
            3: req_va[63:42] = '1;
            4: begin req_phys = 1'b1; req_va[63:44] = '0; end
            default: ;
         endcase
         if (k == 3 && req_va[47:41] == 7'h7e) req_va[41] = 1'b1;
         req_write = 1'($urandom); req_alt = 1'($urandom); req_pte = 1'($urandom);
         pal_mode  = 1'($urandom); cur_mode = 2'($urandom); alt_mode = 2'($urandom);
         tlb_hit   = ($urandom % 4) != 0;
         tlb_ppn   = ($urandom % 4 == 0) ? $urandom : ($urandom & 32'h7FFF_FFFF) >> ($urandom % 8);
         tlb_rd_en = 4'($urandom); tlb_wr_en = 4'($urandom);
         tlb_for   = ($urandom % 4) == 0; tlb_fow = ($urandom % 4) == 0;
         launch("R1-random mix R2 R9 R12");
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got no completion expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule